// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is a 16-bit event counter that produces repeating intervals. Each count event comes from one of two kinds of source. The first is a pin, qualified on its rising or its falling edge. The second is one of four power-of-two divisions of the system clock. After every step the new count is compared with a 16-bit reference. When the two are equal, the block raises a sticky interrupt request and flips a toggle flop. The next event then returns the count to zero, so the intervals repeat with a period of reference+1 events.

Software controls the timer through a small 8-bit register bus:

| Address | Access | Contents |
|---|---|---|
| 0 | read/write | Mode register |
| 1 | read/write | Reference, low byte |
| 2 | read/write | Reference, high byte |
| 3 | read-only | Count, low byte |
| 4 | read-only | Count, high byte, taken from a shadow copy |
| 5 | read/write | Interrupt flag |

Mode register fields:
- Bit 0 gates the toggle onto the output pin.
- Bit 2 is a start strobe.
- Bit 3 enables counting.
- Bits 6:4 select the event source.

A mode write that sets bits 3 and 2 together clears and restarts the count. It also restarts the internal prescaler, so the clock-derived rates begin at a known phase.

Top module: `ivl_timer`

## Requirements
- R1: After reset, every readable register reads 0x00. The interrupt output and the timer output pin are both low.
- R2: Writes to address 3 and address 4 are ignored. The count value read back afterwards is unchanged.
- R3: A write to address 0 with both bit 3 and bit 2 set clears the count to zero and starts counting. Bit 2 is not stored. The mode register reads back bits 6:4, bit 3 and bit 0 only, so a write of 0x7C reads back as 0x78.
- R4: Source code 000 counts one event per rising edge of `ext_in`. Source code 001 counts one event per falling edge. The input passes through a two-flop synchronizer, so the count changes on the third clock edge after the input changes.
- R5: Source codes 100, 101, 110 and 111 count once every 1024, 256, 64 and 8 system clocks. Measured from the clock edge that accepts a start write, the count t edges later equals floor(t/N).
- R6: Source codes 010 and 011 select no event source. While either is selected, or while mode bit 3 is clear, the count holds its value.
- R7: When a step makes the count equal to the reference, the interrupt flag (address 5, bit 0, and output `irq`) becomes 1 on that same clock edge.
- R8: The first event after a match returns the count to 0. One interval therefore spans reference+1 events.
- R9: The flag stays set until software writes address 5 with bit 0 set. Writing 0 to bit 0 has no effect. If a match happens in the same cycle as a clear, the flag stays set.
- R10: Each match inverts an internal toggle state. `tmr_out` shows this state only while mode bit 0 is 1 and is low otherwise. The toggle state keeps updating while the pin is gated off.
- R11: A read of address 3 copies the current high count byte into a shadow register. Address 4 returns that shadow copy, so a low-then-high read pair gives a coherent 16-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_in | input | 1 | External count input, asynchronous |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, used to latch the count shadow |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Sticky interrupt request |
| tmr_out | output | 1 | Gated toggle output |

## Verification
Most internal faults reach the ports within one interval.

- A wrong prescaler tap or a mis-ordered source decode shows up as a count byte that is off by a whole step after a few multiples of the chosen division.
- A wrong wrap or compare shows up on `irq` and `tmr_out` at the reference+1-th event. It appears either as a count that runs past the reference or as a flag that is set one event early or late.
- Shadow or flag-priority faults show up only in narrow windows: a high-byte read taken after the low byte has rolled over, or a clear written in the exact match cycle. The bench sets up both windows explicitly.

// File: rtl/ivl_timer_pkg.sv
// Package: shared constants for the interval timer.
// Holds the register map, the source-select codes and the prescaler tap
// exponents. It assumes a 3-bit bus address and a 3-bit source field.
package ivl_timer_pkg;

    localparam logic [2:0] ADDR_MODE  = 3'd0;
    localparam logic [2:0] ADDR_REF_L = 3'd1;
    localparam logic [2:0] ADDR_REF_H = 3'd2;
    localparam logic [2:0] ADDR_CNT_L = 3'd3;
    localparam logic [2:0] ADDR_CNT_H = 3'd4;
    localparam logic [2:0] ADDR_FLAG  = 3'd5;

    // Mode register bit positions
    localparam int MODE_OE    = 0;
    localparam int MODE_START = 2;
    localparam int MODE_RUN   = 3;
    localparam int MODE_SRC_L = 4;

    // Mode register bits that are actually stored
    localparam logic [7:0] MODE_KEEP = 8'h79;

    typedef enum logic [2:0] {
        SRC_EXT_RISE = 3'b000,
        SRC_EXT_FALL = 3'b001,
        SRC_NONE_A   = 3'b010,
        SRC_NONE_B   = 3'b011,
        SRC_DIV_1024 = 3'b100,
        SRC_DIV_256  = 3'b101,
        SRC_DIV_64   = 3'b110,
        SRC_DIV_8    = 3'b111
    } src_sel_e;

    // Prescaler taps, indexed by the low two bits of the source code
    localparam int NUM_RATES = 4;
    localparam int RATE_SHIFT [NUM_RATES] = '{10, 8, 6, 3};

endpackage

// File: rtl/ivl_event_gen.sv
// Module: ivl_event_gen
// Turns the selected source into single-cycle count events.
// Assumptions:
// - ext_in is asynchronous, so it passes through a two-flop synchronizer
//   followed by an edge detector.
// - The prescaler is free running. It restarts whenever the count is
//   restarted, which gives the clock-derived rates a fixed phase.
// - Every tap exponent is no larger than PRESC_W.
module ivl_event_gen
    import ivl_timer_pkg::*;
#(
    parameter int PRESC_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       ext_in,
    input  logic [2:0] src_sel,
    output logic       cnt_evt
);

    logic [2:0]           sync_q;
    logic                 ext_rise;
    logic                 ext_fall;
    logic [PRESC_W-1:0]   presc_q;
    logic [NUM_RATES-1:0] rate_tick;

    // Synchronize ext_in and keep one extra stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], ext_in};
    end

    assign ext_rise =  sync_q[1] & ~sync_q[2];
    assign ext_fall = ~sync_q[1] &  sync_q[2];

    // Free-running prescaler, cleared on reset and on a counter restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart) presc_q <= '0;
        else                   presc_q <= presc_q + 1'b1;
    end

    // One tap per rate: a pulse when the low bits of the prescaler are all ones
    for (genvar i = 0; i < NUM_RATES; i++) begin : g_tap
        localparam logic [PRESC_W-1:0] TAP_MASK =
            PRESC_W'((32'd1 << RATE_SHIFT[i]) - 32'd1);
        assign rate_tick[i] = ((presc_q & TAP_MASK) == TAP_MASK);
    end

    // Pick the event source named by the mode field
    always_comb begin
        case (src_sel)
            SRC_EXT_RISE: cnt_evt = ext_rise;
            SRC_EXT_FALL: cnt_evt = ext_fall;
            SRC_DIV_1024,
            SRC_DIV_256,
            SRC_DIV_64,
            SRC_DIV_8:    cnt_evt = rate_tick[src_sel[1:0]];
            default:      cnt_evt = 1'b0;
        endcase
    end

    // R4: an edge of the external input yields a pulse lasting one cycle
    a_r4_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rise |=> !ext_rise);
    a_r4_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        ext_fall |=> !ext_fall);

endmodule

// File: rtl/ivl_count_core.sv
// Module: ivl_count_core
// Counts qualified events, compares each new value with the reference,
// wraps the count after a match, and holds the sticky flag and the
// toggle state.
// Assumptions:
// - start has priority over a step in the same cycle.
// - A match has priority over a flag clear in the same cycle.
module ivl_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start,
    input  logic             evt,
    input  logic             flag_clr,
    input  logic [CNT_W-1:0] ref_val,
    output logic [CNT_W-1:0] count,
    output logic             irq_flag,
    output logic             tgl
);

    logic             step;
    logic             at_ref;
    logic [CNT_W-1:0] nxt_count;
    logic             match;

    assign step      = run & evt;
    assign at_ref    = (count == ref_val);
    assign nxt_count = at_ref ? '0 : count + 1'b1;
    assign match     = step & ~start & (nxt_count == ref_val);

    // Count register: restart clears it, a step advances or wraps it
    always_ff @(posedge clk) begin
        if (!rst_n || start) count <= '0;
        else if (step)       count <= nxt_count;
    end

    // Sticky interrupt flag: a match sets it, software clears it
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_flag <= 1'b0;
        else if (match)    irq_flag <= 1'b1;
        else if (flag_clr) irq_flag <= 1'b0;
    end

    // Toggle state flips on every match
    always_ff @(posedge clk) begin
        if (!rst_n)     tgl <= 1'b0;
        else if (match) tgl <= ~tgl;
    end

    // R3: a restart leaves the count at zero
    a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count == '0));
    // R8: a step taken while at the reference returns the count to zero
    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_ref && !start) |=> (count == '0));
    // R6: with no qualified step the count holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !start) |=> $stable(count));
    // R7: after a match the flag is set
    a_r7_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> irq_flag);
    // R9: the flag stays set until a clear arrives
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag);
    // R10: every match flips the toggle state
    a_r10_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (tgl != $past(tgl)));

endmodule

// File: rtl/ivl_timer.sv
// Module: ivl_timer (top)
// Interval timer with an 8-bit register bus.
// Contents: the mode, reference and count-shadow registers, plus the
// write decode and the read mux. Event generation and counting live in
// the two submodules.
// Assumptions:
// - CNT_W is 16, so the count splits into exactly two bytes.
// - Writes last one cycle on bus_wr.
// - bus_rdata is combinational from bus_addr.
module ivl_timer
    import ivl_timer_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PRESC_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_in,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_rd,
    output logic [7:0] bus_rdata,
    output logic       irq,
    output logic       tmr_out
);

    localparam int BYTE_W = 8;

    logic [7:0]        mode_q;
    logic [CNT_W-1:0]  ref_q;
    logic [BYTE_W-1:0] cnt_hi_shadow;
    logic              start;
    logic              flag_clr;
    logic              cnt_evt;
    logic [CNT_W-1:0]  count;
    logic              irq_flag;
    logic              tgl;
    logic              lo_read;

    assign start    = bus_wr && (bus_addr == ADDR_MODE) &&
                      bus_wdata[MODE_RUN] && bus_wdata[MODE_START];
    assign flag_clr = bus_wr && (bus_addr == ADDR_FLAG) && bus_wdata[0];
    assign lo_read  = bus_rd && (bus_addr == ADDR_CNT_L);

    // Mode register: keeps the source, enable and output-enable bits
    always_ff @(posedge clk) begin
        if (!rst_n)                                 mode_q <= '0;
        else if (bus_wr && bus_addr == ADDR_MODE)   mode_q <= bus_wdata & MODE_KEEP;
    end

    // Reference register, written one byte at a time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else if (bus_wr && bus_addr == ADDR_REF_L) begin
            ref_q[BYTE_W-1:0] <= bus_wdata;
        end else if (bus_wr && bus_addr == ADDR_REF_H) begin
            ref_q[CNT_W-1:BYTE_W] <= bus_wdata;
        end
    end

    // High-byte shadow, loaded whenever the low byte is read
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_hi_shadow <= '0;
        else if (lo_read) cnt_hi_shadow <= count[CNT_W-1:BYTE_W];
    end

    // Read mux over the register map
    always_comb begin
        case (bus_addr)
            ADDR_MODE:  bus_rdata = mode_q;
            ADDR_REF_L: bus_rdata = ref_q[BYTE_W-1:0];
            ADDR_REF_H: bus_rdata = ref_q[CNT_W-1:BYTE_W];
            ADDR_CNT_L: bus_rdata = count[BYTE_W-1:0];
            ADDR_CNT_H: bus_rdata = cnt_hi_shadow;
            ADDR_FLAG:  bus_rdata = {7'd0, irq_flag};
            default:    bus_rdata = '0;
        endcase
    end

    ivl_event_gen #(
        .PRESC_W (PRESC_W)
    ) u_event_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .ext_in  (ext_in),
        .src_sel (mode_q[MODE_SRC_L+2:MODE_SRC_L]),
        .cnt_evt (cnt_evt)
    );

    ivl_count_core #(
        .CNT_W (CNT_W)
    ) u_count_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (mode_q[MODE_RUN]),
        .start    (start),
        .evt      (cnt_evt),
        .flag_clr (flag_clr),
        .ref_val  (ref_q),
        .count    (count),
        .irq_flag (irq_flag),
        .tgl      (tgl)
    );

    assign irq     = irq_flag;
    assign tmr_out = mode_q[MODE_OE] & tgl;

    // R11: the shadow changes only on a low-byte read
    a_r11_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_read |=> $stable(cnt_hi_shadow));
    // R3: the start bit never lands in the stored mode
    a_r3_start_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !mode_q[MODE_START]);

endmodule

// File: tb/ivl_timer_bench.sv
`timescale 1ns/1ps
module ivl_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_in = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       tmr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ivl_timer u_ivl_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_in    (ext_in),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .tmr_out   (tmr_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // All tasks below start and end just after a falling edge
    task automatic do_reset();
        rst_n  = 1'b0;
        ext_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ext_level(input logic v);
        ext_in = v;
        wait_cyc(5);
    endtask

    task automatic ext_pulse();
        ext_level(1'b1);
        ext_level(1'b0);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        for (int a = 0; a < 6; a++) begin
            bus_read(3'(a), d);
            check($sformatf("R1 reg %0d after reset", a), d, 0);
        end
        check("R1 irq after reset", irq, 0);
        check("R1 tmr_out after reset", tmr_out, 0);
    endtask

    task automatic t_start_readonly();
        logic [7:0] d;
        logic [7:0] c0;
        do_reset();
        bus_write(3'd1, 8'hFF);
        bus_write(3'd2, 8'hFF);
        bus_write(3'd0, 8'h7C);
        bus_read(3'd0, d);
        check("R3 mode readback drops start bit", d, 8'h78);
        wait_cyc(30);
        bus_write(3'd0, 8'h7C);
        bus_read(3'd3, d);
        check("R3 restart clears count", d, 0);
        wait_cyc(30);
        bus_write(3'd0, 8'h70);
        bus_read(3'd3, c0);
        bus_write(3'd3, 8'h55);
        bus_write(3'd4, 8'h66);
        bus_read(3'd3, d);
        check("R2 low count byte ignores writes", d, c0);
        bus_read(3'd4, d);
        check("R2 high count byte ignores writes", d, 0);
    endtask

    task automatic t_rates();
        logic [7:0] d;
        int div [4] = '{1024, 256, 64, 8};
        int k   [4] = '{2, 2, 3, 5};
        do_reset();
        bus_write(3'd1, 8'hFF);
        bus_write(3'd2, 8'hFF);
        for (int i = 0; i < 4; i++) begin
            bus_write(3'd0, 8'(((4 + i) << 4) | 8'h0C));
            wait_cyc(div[i] * k[i]);
            bus_read(3'd3, d);
            check($sformatf("R5 count after %0d cycles at div %0d",
                            div[i] * k[i], div[i]), d, k[i]);
        end
    endtask

    task automatic t_ext_edges();
        logic [7:0] d;
        do_reset();
        bus_write(3'd1, 8'hFF);
        bus_write(3'd2, 8'hFF);
        bus_write(3'd0, 8'h0C);
        ext_level(1'b1);
        bus_read(3'd3, d);
        check("R4 rising mode counts rising edge", d, 1);
        ext_level(1'b0);
        bus_read(3'd3, d);
        check("R4 rising mode ignores falling edge", d, 1);
        ext_pulse();
        ext_pulse();
        bus_read(3'd3, d);
        check("R4 rising mode three pulses", d, 3);
        bus_write(3'd0, 8'h1C);
        ext_level(1'b1);
        bus_read(3'd3, d);
        check("R4 falling mode ignores rising edge", d, 0);
        ext_level(1'b0);
        bus_read(3'd3, d);
        check("R4 falling mode counts falling edge", d, 1);
    endtask

    task automatic t_hold();
        logic [7:0] d;
        do_reset();
        bus_write(3'd1, 8'hFF);
        bus_write(3'd2, 8'hFF);
        bus_write(3'd0, 8'h2C);
        ext_pulse();
        wait_cyc(40);
        bus_read(3'd3, d);
        check("R6 source 010 holds count", d, 0);
        bus_write(3'd0, 8'h3C);
        ext_pulse();
        wait_cyc(40);
        bus_read(3'd3, d);
        check("R6 source 011 holds count", d, 0);
        bus_write(3'd0, 8'h7C);
        wait_cyc(40);
        bus_read(3'd3, d);
        check("R6 count before disable", d, 5);
        bus_write(3'd0, 8'h70);
        wait_cyc(40);
        bus_read(3'd3, d);
        check("R6 enable bit clear holds count", d, 5);
    endtask

    task automatic t_match_wrap();
        logic [7:0] d;
        do_reset();
        bus_write(3'd1, 8'h02);
        bus_write(3'd0, 8'h0D);
        ext_pulse();
        check("R7 no flag before match", irq, 0);
        ext_pulse();
        bus_read(3'd3, d);
        check("R7 count at reference", d, 2);
        check("R7 flag set on match", irq, 1);
        check("R10 pin toggles high on first match", tmr_out, 1);
        ext_pulse();
        bus_read(3'd3, d);
        check("R8 event after match wraps to zero", d, 0);
        check("R9 flag stays set", irq, 1);
        ext_pulse();
        ext_pulse();
        check("R10 pin toggles low on second match", tmr_out, 0);
        bus_write(3'd0, 8'h08);
        check("R10 pin low with output disabled", tmr_out, 0);
        ext_pulse();
        ext_pulse();
        ext_pulse();
        bus_read(3'd3, d);
        check("R8 period is reference+1 events", d, 2);
        check("R10 pin stays low while gated", tmr_out, 0);
        bus_write(3'd0, 8'h09);
        check("R10 gated toggle state still updated", tmr_out, 1);
    endtask

    task automatic t_flag();
        logic [7:0] d;
        do_reset();
        bus_write(3'd1, 8'h02);
        bus_write(3'd0, 8'h7C);
        wait_cyc(15);
        bus_write(3'd5, 8'h01);
        check("R9 match beats same-cycle clear", irq, 1);
        bus_write(3'd5, 8'h00);
        bus_read(3'd5, d);
        check("R9 writing zero keeps flag", d, 1);
        bus_write(3'd5, 8'h01);
        bus_read(3'd5, d);
        check("R9 clear strobe clears flag", d, 0);
        wait_cyc(25);
        bus_read(3'd5, d);
        check("R7 next interval sets flag again", d, 1);
    endtask

    task automatic t_shadow();
        logic [7:0] d;
        do_reset();
        bus_write(3'd1, 8'hFF);
        bus_write(3'd2, 8'hFF);
        bus_write(3'd0, 8'h7C);
        wait_cyc(2042);
        bus_read(3'd3, d);
        check("R11 low byte before rollover", d, 8'hFF);
        wait_cyc(20);
        bus_read(3'd4, d);
        check("R11 high byte is latched copy", d, 0);
        bus_read(3'd3, d);
        bus_read(3'd4, d);
        check("R11 new low read refreshes high byte", d, 1);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_start_readonly();
        t_rates();
        t_ext_edges();
        t_hold();
        t_match_wrap();
        t_flag();
        t_shadow();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule